// File: doc/BRIEF.md
# Charge pump current mode controller

This block is the digital control for the three charge pumps of a frequency synthesizer: a proportional pump and an integral pump that the main phase detector drives, and an auxiliary pump that the auxiliary phase detector drives. It reads a two-bit gain code and two speed-up override bits. It also reads the host's register-load strobe, the flag that marks the tuning word, and a power-down level. From these it decides, every clock cycle, which pumps may run and how much current each one draws. Current is given as a multiple of a unit bias current.

The main pumps enter a fast-tuning speed-up state by default. This state lasts exactly as long as the host holds the load strobe high after loading the tuning word. The host therefore sets the speed-up time as a count of strobe cycles, and the block applies no timeout of its own. One override bit holds speed-up on. The other blocks it, and blocking wins when both bits are set.

All current magnitudes are unsigned integers counted in half-unit steps, so every multiple is exact. All outputs are registered and show the inputs sampled at the previous clock edge.

Top module: `cpump_mode_ctrl`

## Requirements
- R1: While `rst` is sampled high, every output goes to 0 at that edge: enables, magnitudes and `fast_active`.
- R2: In half units, the auxiliary magnitude is 3 for `gain_code` 00 and 10, and 1 for 01 and 11. The normal proportional magnitude is 6 for 00 and 10, and 2 for 01 and 11.
- R3: A speed-up window opens at an edge where `load_stb` is sampled high while it was low at the previous edge, and `load_is_tune` is high at that same edge. It stays open at each later edge where `load_stb` is still high. `fast_active` is high in the cycle after every edge at which the window is open, so its width equals the strobe width. A strobe that rises with `load_is_tune` low opens no window, even if the flag goes high while the strobe is still high.
- R4: When `fast_hold` is 1, `pwr_down` is 0 and `fast_inhibit` is 0, `fast_active` is 1 in the next cycle, whatever the strobe does.
- R5: When `fast_inhibit` is 1, `fast_active` is 0 in the next cycle. This also holds when `fast_hold` is 1.
- R6: In the next cycle, `prop_mag` is the speed-up value when `fast_active` is 1 and the normal value otherwise. The speed-up value is 30 for `gain_code` 00 and 10, and 10 for 01 and 11.
- R7: `int_mag` is 72 for `gain_code` 00, 24 for 01, and 0 whenever `gain_code[1]` is 1. `int_en` is 1 only during speed-up and only when `gain_code[1]` was 0.
- R8: When `pwr_down` is sampled high, all three enables and `fast_active` are 0 in the next cycle. Power-down also closes an open window. A strobe that rises during power-down opens no window, even if power returns while the strobe is still high.
- R9: When `pwr_down` is 0 and the block is out of reset, `aux_en` and `prop_en` are 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gain_code | input | 2 | Pump gain code; bit 1 also shuts off the integral pump |
| fast_hold | input | 1 | Keep speed-up on continuously |
| fast_inhibit | input | 1 | Never enter speed-up |
| load_stb | input | 1 | Host register-load strobe |
| load_is_tune | input | 1 | The word being loaded is the tuning word |
| pwr_down | input | 1 | Effective power-down level |
| aux_en | output | 1 | Auxiliary pump enable |
| aux_mag | output | 8 | Auxiliary current, half units |
| prop_en | output | 1 | Proportional pump enable |
| prop_mag | output | 8 | Proportional current, half units |
| int_en | output | 1 | Integral pump enable |
| int_mag | output | 8 | Integral current, half units |
| fast_active | output | 1 | Speed-up active |

## Verification
The hardest cases to reach are the strobes that must not open a window. One is a strobe whose rise was not qualified by the tuning flag and that then gains the flag while it is still high. The other is a strobe that rises during power-down and is still high when power returns. Directed sequences build both cases edge by edge. A separate directed sequence checks that a qualified strobe of a chosen width gives exactly that many speed-up cycles. Random stimulus then draws the strobe with long runs, and the override bits and power-down rarely, so that full windows often occur alongside mid-window interruptions.

// File: rtl/cpump_pkg.sv
package cpump_pkg;
    localparam int MAG_W     = 8;
    localparam int NPUMP     = 3;
    localparam int LOW_DIV   = 3;   // low-gain codes use one third of the current
    localparam int AUX_BASE  = 3;   // half units
    localparam int PROP_BASE = 6;
    localparam int FAST_BASE = 30;
    localparam int INT_BASE  = 72;

    typedef logic [MAG_W-1:0] mag_t;

    typedef enum int {PUMP_AUX = 0, PUMP_PROP = 1, PUMP_INT = 2} pump_idx_e;

    typedef struct packed {
        logic int_off;   // code bit 1
        logic low_gain;  // code bit 0
    } gain_t;

    typedef struct packed {
        logic en;
        mag_t mag;
    } pump_t;

    typedef struct packed {
        mag_t aux;
        mag_t prop;
        mag_t prop_fast;
        mag_t integ;
    } mag_set_t;

    function automatic mag_t scale(input int base, input logic low);
        int v;
        v = low ? base / LOW_DIV : base;
        return mag_t'(v);
    endfunction

    function automatic mag_set_t lookup(input gain_t g);
        mag_set_t m;
        m.aux       = scale(AUX_BASE, g.low_gain);
        m.prop      = scale(PROP_BASE, g.low_gain);
        m.prop_fast = scale(FAST_BASE, g.low_gain);
        m.integ     = g.int_off ? '0 : scale(INT_BASE, g.low_gain);
        return m;
    endfunction
endpackage

// File: rtl/cpump_window.sv
module cpump_window (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic is_tune,
    input  logic pd,
    output logic win_next
);
    logic stb_q;
    logic win_q;

    // opens on a qualified strobe rise, follows the strobe level afterwards
    always_comb begin
        win_next = stb && !pd && (win_q || (!stb_q && is_tune));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q <= 1'b0;
            win_q <= 1'b0;
        end else begin
            stb_q <= stb;
            win_q <= win_next;
        end
    end
endmodule

// File: rtl/cpump_gain_lut.sv
module cpump_gain_lut
    import cpump_pkg::*;
(
    input  logic [1:0] code,
    output mag_set_t   mags
);
    gain_t g;
    always_comb begin
        g    = gain_t'(code);
        mags = lookup(g);
    end
endmodule

// File: rtl/cpump_mode_ctrl.sv
module cpump_mode_ctrl
    import cpump_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       gain_code,
    input  logic             fast_hold,
    input  logic             fast_inhibit,
    input  logic             load_stb,
    input  logic             load_is_tune,
    input  logic             pwr_down,
    output logic             aux_en,
    output logic [MAG_W-1:0] aux_mag,
    output logic             prop_en,
    output logic [MAG_W-1:0] prop_mag,
    output logic             int_en,
    output logic [MAG_W-1:0] int_mag,
    output logic             fast_active
);
    logic     win_next;
    logic     fast_next;
    logic     fast_q;
    mag_set_t mags;
    gain_t    g;
    pump_t    pump_d [NPUMP];
    pump_t    pump_q [NPUMP];

    cpump_window u_win (
        .clk      (clk),
        .rst      (rst),
        .stb      (load_stb),
        .is_tune  (load_is_tune),
        .pd       (pwr_down),
        .win_next (win_next)
    );

    cpump_gain_lut u_lut (
        .code (gain_code),
        .mags (mags)
    );

    always_comb begin
        g         = gain_t'(gain_code);
        // inhibit has priority over hold
        fast_next = !pwr_down && !fast_inhibit && (fast_hold || win_next);

        pump_d[PUMP_AUX].en   = !pwr_down;
        pump_d[PUMP_AUX].mag  = mags.aux;
        pump_d[PUMP_PROP].en  = !pwr_down;
        pump_d[PUMP_PROP].mag = fast_next ? mags.prop_fast : mags.prop;
        pump_d[PUMP_INT].en   = fast_next && !g.int_off;
        pump_d[PUMP_INT].mag  = mags.integ;
    end

    for (genvar i = 0; i < NPUMP; i++) begin : g_pump
        always_ff @(posedge clk) begin
            if (rst) pump_q[i] <= '0;
            else     pump_q[i] <= pump_d[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fast_q <= 1'b0;
        else     fast_q <= fast_next;
    end

    assign aux_en      = pump_q[PUMP_AUX].en;
    assign aux_mag     = pump_q[PUMP_AUX].mag;
    assign prop_en     = pump_q[PUMP_PROP].en;
    assign prop_mag    = pump_q[PUMP_PROP].mag;
    assign int_en      = pump_q[PUMP_INT].en;
    assign int_mag     = pump_q[PUMP_INT].mag;
    assign fast_active = fast_q;
endmodule

// File: rtl/cpump_mode_chk.sv
module cpump_mode_chk
    import cpump_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [1:0]       gain_code,
    input logic             fast_hold,
    input logic             fast_inhibit,
    input logic             load_stb,
    input logic             pwr_down,
    input logic             aux_en,
    input logic [MAG_W-1:0] aux_mag,
    input logic             prop_en,
    input logic [MAG_W-1:0] prop_mag,
    input logic             int_en,
    input logic             fast_active
);
    // R8
    pd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> !aux_en && !prop_en && !int_en && !fast_active);

    // R5
    inhibit_wins_chk: assert property (@(posedge clk) disable iff (rst)
        fast_inhibit |=> !fast_active);

    // R4
    hold_forces_chk: assert property (@(posedge clk) disable iff (rst)
        fast_hold && !fast_inhibit && !pwr_down |=> fast_active);

    // R3
    no_strobe_no_fast_chk: assert property (@(posedge clk) disable iff (rst)
        !load_stb && !fast_hold |=> !fast_active);

    // R7
    int_needs_fast_chk: assert property (@(posedge clk) disable iff (rst)
        int_en |-> fast_active && !$past(gain_code[1]));

    // R6
    prop_fast_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        aux_en && fast_active |-> int'(prop_mag) == 10 * int'(aux_mag));

    // R6
    prop_norm_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        aux_en && !fast_active |-> int'(prop_mag) == 2 * int'(aux_mag));

    // R9
    on_enables_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_down |=> aux_en && prop_en);
endmodule

bind cpump_mode_ctrl cpump_mode_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .gain_code    (gain_code),
    .fast_hold    (fast_hold),
    .fast_inhibit (fast_inhibit),
    .load_stb     (load_stb),
    .pwr_down     (pwr_down),
    .aux_en       (aux_en),
    .aux_mag      (aux_mag),
    .prop_en      (prop_en),
    .prop_mag     (prop_mag),
    .int_en       (int_en),
    .fast_active  (fast_active)
);

// File: tb/sim_cpump_mode_ctrl.sv
`timescale 1ns/100ps
module sim_cpump_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] gain_code = 2'b00;
    logic       fast_hold = 1'b0, fast_inhibit = 1'b0;
    logic       load_stb = 1'b0, load_is_tune = 1'b0, pwr_down = 1'b0;
    logic       aux_en, prop_en, int_en, fast_active;
    logic [7:0] aux_mag, prop_mag, int_mag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model state
    bit m_win = 1'b0;
    bit m_stb = 1'b0;

    always #2.5 clk = ~clk;

    cpump_mode_ctrl u0 (
        .clk(clk), .rst(rst), .gain_code(gain_code),
        .fast_hold(fast_hold), .fast_inhibit(fast_inhibit),
        .load_stb(load_stb), .load_is_tune(load_is_tune), .pwr_down(pwr_down),
        .aux_en(aux_en), .aux_mag(aux_mag), .prop_en(prop_en), .prop_mag(prop_mag),
        .int_en(int_en), .int_mag(int_mag), .fast_active(fast_active)
    );

    function automatic int exp_aux(input logic [1:0] c);
        return c[0] ? 1 : 3;
    endfunction
    function automatic int exp_prop(input logic [1:0] c, input bit fast);
        if (fast) return c[0] ? 10 : 30;
        return c[0] ? 2 : 6;
    endfunction
    function automatic int exp_int(input logic [1:0] c);
        case (c)
            2'b00:   return 72;
            2'b01:   return 24;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, compare after the next posedge
    task automatic step(input logic [1:0] c, input bit h, input bit i,
                        input bit s, input bit t, input bit p);
        bit wn, fn;
        @(negedge clk);
        gain_code = c; fast_hold = h; fast_inhibit = i;
        load_stb = s; load_is_tune = t; pwr_down = p;
        @(posedge clk);
        #1;
        wn    = s && !p && (m_win || (!m_stb && t));
        m_win = wn;
        m_stb = s;
        fn    = !p && !i && (h || wn);
        chk(fast_active == fn, "R3/R4/R5 fast_active", int'(fast_active), int'(fn));
        chk(aux_en == !p && prop_en == !p, "R9/R8 aux_en,prop_en",
            int'({aux_en, prop_en}), int'({!p, !p}));
        chk(int'(aux_mag) == exp_aux(c), "R2 aux_mag", int'(aux_mag), exp_aux(c));
        chk(int'(prop_mag) == exp_prop(c, fn), "R6 prop_mag", int'(prop_mag), exp_prop(c, fn));
        chk(int_en == (fn && !c[1]), "R7 int_en", int'(int_en), int'(fn && !c[1]));
        chk(int'(int_mag) == exp_int(c), "R7 int_mag", int'(int_mag), exp_int(c));
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int fast_cnt;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk({aux_en, prop_en, int_en, fast_active} == 4'b0, "R1 enables", 
            int'({aux_en, prop_en, int_en, fast_active}), 0);
        chk(aux_mag == 0 && prop_mag == 0 && int_mag == 0, "R1 magnitudes",
            int'(aux_mag) + int'(prop_mag) + int'(int_mag), 0);
        @(negedge clk);
        rst = 1'b0;

        // R2 every gain code, idle
        for (int c = 0; c < 4; c++) step(2'(c), 0, 0, 0, 0, 0);

        // R3 qualified strobe of width 5 gives five speed-up cycles
        fast_cnt = 0;
        step(2'b00, 0, 0, 0, 0, 0);
        for (int k = 0; k < 5; k++) begin
            step(2'b00, 0, 0, 1, (k == 0), 0);
            fast_cnt += int'(fast_active);
        end
        step(2'b00, 0, 0, 0, 0, 0);
        fast_cnt += int'(fast_active);
        chk(fast_cnt == 5, "R3 window width", fast_cnt, 5);

        // R3 unqualified rise, flag arrives late: no window
        step(2'b01, 0, 0, 1, 0, 0);
        step(2'b01, 0, 0, 1, 1, 0);
        chk(!fast_active, "R3 late flag", int'(fast_active), 0);
        step(2'b01, 0, 0, 0, 0, 0);

        // R4 hold, R5 inhibit priority, R7 integral off with bit 1
        step(2'b10, 1, 0, 0, 0, 0);
        step(2'b00, 1, 0, 0, 0, 0);
        step(2'b00, 1, 1, 0, 0, 0);
        chk(!fast_active, "R5 inhibit over hold", int'(fast_active), 0);
        step(2'b00, 0, 1, 1, 1, 0);
        step(2'b00, 0, 0, 0, 0, 0);

        // R8 power-down mid-window closes it
        step(2'b00, 0, 0, 1, 1, 0);
        step(2'b00, 0, 0, 1, 0, 1);
        step(2'b00, 0, 0, 1, 0, 0);
        chk(!fast_active, "R8 window closed", int'(fast_active), 0);
        step(2'b00, 0, 0, 0, 0, 0);
        // R8 strobe rising during power-down, power returns while high
        step(2'b01, 0, 0, 1, 1, 1);
        step(2'b01, 0, 0, 1, 1, 0);
        step(2'b01, 0, 0, 1, 0, 0);
        chk(!fast_active, "R8 strobe in power-down", int'(fast_active), 0);
        step(2'b01, 0, 0, 0, 0, 0);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            bit s;
            s = (($urandom % 8) < 3) ? !load_stb : load_stb;
            step(2'($urandom), ($urandom % 10) == 0, ($urandom % 12) == 0,
                 s, ($urandom % 2) == 0, ($urandom % 20) == 0);
        end

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1; fast_hold = 1'b1; pwr_down = 1'b0;
        @(posedge clk);
        #1;
        chk(!fast_active && !aux_en && aux_mag == 0, "R1 reset again",
            int'({fast_active, aux_en}), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule